// File: doc/BRIEF.md
# SPI Memory Operation Sequencer

This block runs one memory-style transaction on a four-lane serial bus. A host presents a descriptor and pulses `start`. The descriptor holds an opcode, an address of 0 to 8 bytes, a count of dummy bytes, and a data phase that reads or writes a given number of bytes. Each of the four parts has its own lane width of 1, 2 or 4. The block first checks the widths against four capability inputs. It rejects an operation the link cannot carry, and the bus never moves for that operation. An accepted operation pulls chip select low, and the parts then go out in a fixed order. Any part whose byte count is zero is skipped.

Write data comes in on a byte-wide valid/ready stream. Read data leaves on another one. Both streams apply back-pressure by stalling the serial clock low between bytes, with chip select held. A write byte moves when `wr_valid` and `wr_ready` are both high at a rising `clk` edge. `wr_ready` depends only on internal state, never on `wr_valid`. A read byte stays on `rd_data` with `rd_valid` high until `rd_ready` accepts it, and only then does the bus resume. At the end, the number of bytes actually shifted is compared with the sum of the four byte counts. `done` pulses together with any error flags.

Top module: `spimem_seq`

## Requirements
- R1: Parts go out in the order opcode (one byte), address, dummy, data. A part with a byte count of zero produces no serial clock edges, so an operation has exactly 8/Wc + A·8/Wa + D·8/Wd + N·8/Wx rising edges of `sclk`.
- R2: A lane width is accepted as follows. Width 1 is always accepted. Width 2 needs dual or quad on that side. Width 4 needs quad on that side. Any other value is refused. A read data part is judged against the receive capabilities (`cap_rx_*`). The opcode, address, dummy and write-data parts are judged against the transmit capabilities (`cap_tx_*`). A part whose count is zero is not judged.
- R3: A refused operation never pulls `cs_n` low. If `start` is sampled at clock edge t, then `done` and `err_unsup` are high in the cycle that follows t.
- R4: Only the low `op_addr_len` bytes of `op_addr` are sent, most significant byte first.
- R5: Every dummy byte is sent as 0xFF on the dummy part's lanes.
- R6: For width N, each byte is cut into 8/N groups, with the most significant group first. Within a group, lane i carries bit 8−N·(g+1)+i. Output parts drive `io_oe` equal to the low N lanes. A read data part drives `io_oe` to 0. A single-lane read samples `io_in[1]`; wider reads sample lanes 0..N−1.
- R7: Mode 0 timing applies. `sclk` is low at rest. `io_out` and `io_oe` change only while `sclk` is low. Input is sampled when `sclk` rises.
- R8: `cs_n` stays low from before the first rising edge of `sclk` to after the last one. It then stays high for at least one `clk` cycle. `sclk` is low whenever `cs_n` is high.
- R9: A write data part accepts exactly N bytes, one per valid/ready transfer, and sends them in the order accepted. While `wr_valid` is low, `sclk` stays low.
- R10: A read data part returns exactly N bytes in bus order. `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low.
- R11: If the count of bytes shifted differs from 1+A+D+N, `err_io` rises with `done`. On a completed operation it stays low.
- R12: `busy` is high from the edge that accepts `start` until `done`. A `start` pulse or a descriptor change while busy has no effect on the operation in flight. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled while idle) |
| cap_tx_dual | input | 1 | Link can transmit on two lanes |
| cap_tx_quad | input | 1 | Link can transmit on four lanes |
| cap_rx_dual | input | 1 | Link can receive on two lanes |
| cap_rx_quad | input | 1 | Link can receive on four lanes |
| op_opcode | input | 8 | Opcode byte |
| op_cmd_lanes | input | 3 | Lane width of the opcode |
| op_addr_len | input | ALEN_W | Address byte count, 0..ADDR_BYTES_MAX |
| op_addr_lanes | input | 3 | Lane width of the address |
| op_addr | input | 8·ADDR_BYTES_MAX | Address value |
| op_dummy_len | input | DUMMY_LEN_W | Dummy byte count |
| op_dummy_lanes | input | 3 | Lane width of the dummy bytes |
| op_data_len | input | DATA_LEN_W | Data byte count |
| op_data_lanes | input | 3 | Lane width of the data |
| op_data_read | input | 1 | 1 = read from memory, 0 = write |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_unsup | output | 1 | With done: operation refused |
| err_io | output | 1 | With done: byte total mismatch |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The checker assumes that the host raises `start` only while `busy` is low. It also assumes that `rd_ready` and `wr_valid` may change freely between edges, but only as functions of earlier outputs. The bench follows this by driving every input on the falling `clk` edge and by deciding each stream transfer from `rd_valid`/`wr_ready` values that were already settled. The bench drives `io_in` from its own count of rising `sclk` edges, so read data always changes after the design has sampled it. One directed case breaks the busy rule on purpose, and only from the bench side, to show that a second `start` and a changed descriptor are ignored.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

  localparam int LANES = 4;

  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_DATA  = 3'd3
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_SHIFT  = 3'd2,
    ST_RDOUT  = 3'd3,
    ST_FINISH = 3'd4
  } state_e;

  // width legality against one side's dual/quad capability
  function automatic logic lane_ok(input logic [2:0] w, input logic dual, input logic quad);
    case (w)
      3'd1:    return 1'b1;
      3'd2:    return dual | quad;
      3'd4:    return quad;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] w);
    case (w)
      3'd2:    return 4'b0011;
      3'd4:    return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [3:0] groups_per_byte(input logic [2:0] w);
    case (w)
      3'd2:    return 4'd4;
      3'd4:    return 4'd2;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/spimem_capgate.sv
module spimem_capgate
  import spimem_pkg::*;
#(
  parameter int ALEN_W      = 4,
  parameter int DUMMY_LEN_W = 4,
  parameter int DATA_LEN_W  = 12
) (
  input  logic                   tx_dual,
  input  logic                   tx_quad,
  input  logic                   rx_dual,
  input  logic                   rx_quad,
  input  logic [2:0]             cmd_w,
  input  logic [2:0]             addr_w,
  input  logic [2:0]             dummy_w,
  input  logic [2:0]             data_w,
  input  logic [ALEN_W-1:0]      addr_len,
  input  logic [DUMMY_LEN_W-1:0] dummy_len,
  input  logic [DATA_LEN_W-1:0]  data_len,
  input  logic                   data_read,
  output logic                   accept
);
  localparam int NPH = 4;

  logic [2:0]     ph_w    [NPH];
  logic [NPH-1:0] ph_used;
  logic [NPH-1:0] ph_rx;
  logic [NPH-1:0] ph_ok;

  always_comb begin
    ph_w[0] = cmd_w;
    ph_w[1] = addr_w;
    ph_w[2] = dummy_w;
    ph_w[3] = data_w;
    ph_used = {data_len != '0, dummy_len != '0, addr_len != '0, 1'b1};
    ph_rx   = {data_read, 3'b000};
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic dual_p, quad_p;
    assign dual_p   = ph_rx[p] ? rx_dual : tx_dual;
    assign quad_p   = ph_rx[p] ? rx_quad : tx_quad;
    assign ph_ok[p] = !ph_used[p] || lane_ok(ph_w[p], dual_p, quad_p);
  end

  assign accept = &ph_ok;

endmodule

// File: rtl/spimem_sclk_div.sv
module spimem_sclk_div #(
  parameter int HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spimem_shifter.sv
module spimem_shifter
  import spimem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       width,
  input  logic             load,
  input  logic [7:0]       load_byte,
  input  logic             sample,    // rising sclk, read part only
  input  logic             advance,   // falling sclk
  input  logic             rx_mode,
  input  logic [LANES-1:0] lanes_in,
  output logic [LANES-1:0] lanes_out,
  output logic             last_grp,
  output logic [7:0]       byte_q
);
  logic [7:0]       sreg_q;
  logic [3:0]       left_q;
  logic [LANES-1:0] in_bits;

  always_comb begin
    case (width)
      3'd2:    in_bits = {2'b00, lanes_in[1:0]};
      3'd4:    in_bits = lanes_in;
      default: in_bits = {3'b000, lanes_in[1]};
    endcase
    case (width)
      3'd2:    lanes_out = {2'b00, sreg_q[7:6]};
      3'd4:    lanes_out = sreg_q[7:4];
      default: lanes_out = {3'b000, sreg_q[7]};
    endcase
  end

  assign last_grp = (left_q == 4'd1);
  assign byte_q   = sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
    end else if (load) begin
      sreg_q <= load_byte;
      left_q <= groups_per_byte(width);
    end else begin
      if (sample) begin
        case (width)
          3'd2:    sreg_q <= {sreg_q[5:0], in_bits[1:0]};
          3'd4:    sreg_q <= {sreg_q[3:0], in_bits};
          default: sreg_q <= {sreg_q[6:0], in_bits[0]};
        endcase
      end
      if (advance) begin
        left_q <= left_q - 1'b1;
        if (!rx_mode) begin
          case (width)
            3'd2:    sreg_q <= {sreg_q[5:0], 2'b00};
            3'd4:    sreg_q <= {sreg_q[3:0], 4'b0000};
            default: sreg_q <= {sreg_q[6:0], 1'b0};
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/spimem_seq.sv
module spimem_seq
  import spimem_pkg::*;
#(
  parameter int ADDR_BYTES_MAX = 8,
  parameter int DUMMY_LEN_W    = 4,
  parameter int DATA_LEN_W     = 12,
  parameter int SCLK_HALF      = 1,
  localparam int ADDR_W        = 8 * ADDR_BYTES_MAX,
  localparam int ALEN_W        = $clog2(ADDR_BYTES_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   cap_tx_dual,
  input  logic                   cap_tx_quad,
  input  logic                   cap_rx_dual,
  input  logic                   cap_rx_quad,
  input  logic [7:0]             op_opcode,
  input  logic [2:0]             op_cmd_lanes,
  input  logic [ALEN_W-1:0]      op_addr_len,
  input  logic [2:0]             op_addr_lanes,
  input  logic [ADDR_W-1:0]      op_addr,
  input  logic [DUMMY_LEN_W-1:0] op_dummy_len,
  input  logic [2:0]             op_dummy_lanes,
  input  logic [DATA_LEN_W-1:0]  op_data_len,
  input  logic [2:0]             op_data_lanes,
  input  logic                   op_data_read,
  input  logic [7:0]             wr_data,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  output logic [7:0]             rd_data,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic                   busy,
  output logic                   done,
  output logic                   err_unsup,
  output logic                   err_io,
  output logic                   sclk,
  output logic                   cs_n,
  output logic [3:0]             io_out,
  output logic [3:0]             io_oe,
  input  logic [3:0]             io_in
);
  localparam int TOT_W = DATA_LEN_W + 2;
  localparam int REM_W = DATA_LEN_W;

  state_e                 state_q;
  phase_e                 phase_q;
  logic [REM_W-1:0]       rem_q;
  logic [TOT_W-1:0]       xfer_q, exp_q;
  logic [7:0]             opc_q;
  logic [2:0]             cw_q, aw_q, dw_q, xw_q;
  logic [ALEN_W-1:0]      alen_q;
  logic [DUMMY_LEN_W-1:0] dlen_q;
  logic [DATA_LEN_W-1:0]  nd_q;
  logic                   rd_q;
  logic [ADDR_W-1:0]      addr_sh_q;
  logic                   sclk_q, cs_n_q, done_q, eu_q, eio_q;

  logic                   gate_ok, tick;
  logic [2:0]             cur_w;
  logic                   rd_part, need_byte, wr_hold;
  logic                   sh_load, sh_sample, sh_adv, sh_last;
  logic [7:0]             sh_byte, sh_q;
  logic [3:0]             sh_lanes;

  spimem_capgate #(
    .ALEN_W(ALEN_W), .DUMMY_LEN_W(DUMMY_LEN_W), .DATA_LEN_W(DATA_LEN_W)
  ) gate_i (
    .tx_dual(cap_tx_dual), .tx_quad(cap_tx_quad),
    .rx_dual(cap_rx_dual), .rx_quad(cap_rx_quad),
    .cmd_w(op_cmd_lanes), .addr_w(op_addr_lanes),
    .dummy_w(op_dummy_lanes), .data_w(op_data_lanes),
    .addr_len(op_addr_len), .dummy_len(op_dummy_len),
    .data_len(op_data_len), .data_read(op_data_read),
    .accept(gate_ok)
  );

  spimem_sclk_div #(.HALF(SCLK_HALF)) div_i (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_SHIFT), .tick(tick)
  );

  always_comb begin
    case (phase_q)
      PH_ADDR:  cur_w = aw_q;
      PH_DUMMY: cur_w = dw_q;
      PH_DATA:  cur_w = xw_q;
      default:  cur_w = cw_q;
    endcase
    rd_part   = (phase_q == PH_DATA) && rd_q;
    need_byte = (state_q == ST_LOAD) && (rem_q != '0);
    wr_hold   = (phase_q == PH_DATA) && !rd_q && !wr_valid;
    sh_load   = need_byte && !wr_hold;
    case (phase_q)
      PH_ADDR:  sh_byte = addr_sh_q[ADDR_W-1 -: 8];
      PH_DUMMY: sh_byte = 8'hFF;
      PH_DATA:  sh_byte = rd_q ? 8'h00 : wr_data;
      default:  sh_byte = opc_q;
    endcase
    sh_sample = (state_q == ST_SHIFT) && tick && !sclk_q && rd_part;
    sh_adv    = (state_q == ST_SHIFT) && tick && sclk_q;
  end

  spimem_shifter shift_i (
    .clk(clk), .rst_n(rst_n), .width(cur_w),
    .load(sh_load), .load_byte(sh_byte),
    .sample(sh_sample), .advance(sh_adv), .rx_mode(rd_part),
    .lanes_in(io_in), .lanes_out(sh_lanes),
    .last_grp(sh_last), .byte_q(sh_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_CMD;
      rem_q     <= '0;
      xfer_q    <= '0;
      exp_q     <= '0;
      opc_q     <= '0;
      cw_q      <= 3'd1;
      aw_q      <= 3'd1;
      dw_q      <= 3'd1;
      xw_q      <= 3'd1;
      alen_q    <= '0;
      dlen_q    <= '0;
      nd_q      <= '0;
      rd_q      <= 1'b0;
      addr_sh_q <= '0;
      sclk_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      done_q    <= 1'b0;
      eu_q      <= 1'b0;
      eio_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      eu_q   <= 1'b0;
      eio_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (gate_ok) begin
              opc_q     <= op_opcode;
              cw_q      <= op_cmd_lanes;
              aw_q      <= op_addr_lanes;
              dw_q      <= op_dummy_lanes;
              xw_q      <= op_data_lanes;
              alen_q    <= op_addr_len;
              dlen_q    <= op_dummy_len;
              nd_q      <= op_data_len;
              rd_q      <= op_data_read;
              addr_sh_q <= op_addr << (8 * (ADDR_BYTES_MAX - int'(op_addr_len)));
              exp_q     <= TOT_W'(1) + TOT_W'(op_addr_len) + TOT_W'(op_dummy_len)
                           + TOT_W'(op_data_len);
              xfer_q    <= '0;
              phase_q   <= PH_CMD;
              rem_q     <= REM_W'(1);
              cs_n_q    <= 1'b0;
              state_q   <= ST_LOAD;
            end else begin
              done_q <= 1'b1;
              eu_q   <= 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (rem_q == '0) begin
            case (phase_q)
              PH_CMD: begin
                phase_q <= PH_ADDR;
                rem_q   <= REM_W'(alen_q);
              end
              PH_ADDR: begin
                phase_q <= PH_DUMMY;
                rem_q   <= REM_W'(dlen_q);
              end
              PH_DUMMY: begin
                phase_q <= PH_DATA;
                rem_q   <= REM_W'(nd_q);
              end
              default: state_q <= ST_FINISH;
            endcase
          end else if (sh_load) begin
            if (phase_q == PH_ADDR) addr_sh_q <= addr_sh_q << 8;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= !sclk_q;
            if (sclk_q && sh_last) begin
              rem_q   <= rem_q - 1'b1;
              xfer_q  <= xfer_q + 1'b1;
              state_q <= rd_part ? ST_RDOUT : ST_LOAD;
            end
          end
        end
        ST_RDOUT: begin
          if (rd_ready) state_q <= ST_LOAD;
        end
        default: begin
          cs_n_q  <= 1'b1;
          done_q  <= 1'b1;
          eio_q   <= (xfer_q != exp_q);
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign wr_ready  = need_byte && (phase_q == PH_DATA) && !rd_q;
  assign rd_valid  = (state_q == ST_RDOUT);
  assign rd_data   = sh_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err_unsup = eu_q;
  assign err_io    = eio_q;
  assign sclk      = sclk_q;
  assign cs_n      = cs_n_q;
  assign io_oe     = ((state_q == ST_SHIFT) && !rd_part) ? lane_mask(cur_w) : 4'b0000;
  assign io_out    = sh_lanes & io_oe;

endmodule

// File: rtl/spimem_seq_chk.sv
module spimem_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_out,
  input logic [3:0] io_oe,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       busy,
  input logic       done,
  input logic       err_unsup
);
  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> ($stable(io_out) && $stable(io_oe)));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_rd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (io_oe == 4'b0000 && !sclk));

  p_wr_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> (!sclk && !cs_n));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));

  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_unsup) |-> (cs_n && $past(cs_n)));

endmodule

bind spimem_seq spimem_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .io_out(io_out), .io_oe(io_oe),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .wr_valid(wr_valid), .wr_ready(wr_ready),
  .busy(busy), .done(done), .err_unsup(err_unsup)
);

// File: tb/spimem_seq_tb_top.sv
module spimem_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst_n, start;
  logic        cap_tx_dual, cap_tx_quad, cap_rx_dual, cap_rx_quad;
  logic [7:0]  op_opcode;
  logic [2:0]  op_cmd_lanes, op_addr_lanes, op_dummy_lanes, op_data_lanes;
  logic [3:0]  op_addr_len, op_dummy_len;
  logic [63:0] op_addr;
  logic [11:0] op_data_len;
  logic        op_data_read;
  logic [7:0]  wr_data, rd_data;
  logic        wr_valid, wr_ready, rd_valid, rd_ready;
  logic        busy, done, err_unsup, err_io, sclk, cs_n;
  logic [3:0]  io_out, io_oe, io_in;

  spimem_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cap_tx_dual(cap_tx_dual), .cap_tx_quad(cap_tx_quad),
    .cap_rx_dual(cap_rx_dual), .cap_rx_quad(cap_rx_quad),
    .op_opcode(op_opcode), .op_cmd_lanes(op_cmd_lanes),
    .op_addr_len(op_addr_len), .op_addr_lanes(op_addr_lanes), .op_addr(op_addr),
    .op_dummy_len(op_dummy_len), .op_dummy_lanes(op_dummy_lanes),
    .op_data_len(op_data_len), .op_data_lanes(op_data_lanes),
    .op_data_read(op_data_read),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .busy(busy), .done(done), .err_unsup(err_unsup), .err_io(err_io),
    .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int n_vec = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus capture on rising sclk; counters clear when cs_n falls
  int         k = 0;
  int         cs_falls = 0;
  logic [3:0] cap_out [0:511];
  logic [3:0] cap_oe  [0:511];

  always @(posedge sclk or negedge cs_n) begin
    if (!sclk) begin
      k        <= 0;
      cs_falls <= cs_falls + 1;
    end else if (k < 512) begin
      cap_out[k] <= io_out;
      cap_oe[k]  <= io_oe;
      k          <= k + 1;
    end
  end

  // current operation as seen by the memory model
  int m_cw = 1, m_aw = 1, m_alen = 0, m_dw = 1, m_dlen = 0, m_xw = 1, m_nd = 0, m_rd = 0;
  int op_idx = 0;

  function automatic int sw(input int w);
    return (w == 1 || w == 2 || w == 4) ? w : 1;
  endfunction

  function automatic int rd_pat(input int j, input int idx);
    return (j * 37 + 5 + idx) & 255;
  endfunction

  function automatic int wr_pat(input int j, input int idx);
    return (j * 29 + idx * 7 + 1) & 255;
  endfunction

  always @* begin
    int base, w, idx, gpb, b, bits;
    base = 8 / sw(m_cw) + m_alen * (8 / sw(m_aw)) + m_dlen * (8 / sw(m_dw));
    w    = sw(m_xw);
    io_in = 4'hA;
    if (m_rd != 0 && k >= base) begin
      idx  = k - base;
      gpb  = 8 / w;
      b    = rd_pat(idx / gpb, op_idx);
      bits = (b >> (8 - w * ((idx % gpb) + 1))) & ((1 << w) - 1);
      if (w == 1) io_in = {2'b00, bits[0], ~bits[0]};
      else        io_in = 4'(bits);
    end
  end

  function automatic bit lane_ok_b(input int w, input bit d, input bit q);
    return (w == 1) || (w == 2 && (d || q)) || (w == 4 && q);
  endfunction

  task automatic run_op(input int cw, input int aw, input int alen, input int dw,
                        input int dlen, input int xw, input int nd, input int rdf,
                        input bit [3:0] caps, input bit poke);
    bit        exp_ok;
    int        cyc, widx, ridx, e, n_edges, bad_tx, bad_oe, bad_rd, falls0;
    bit        hung, saw_busy;
    int        got [0:15];
    int        expb [0:31];
    int        wid  [0:31];
    int        nb;
    logic [7:0] opc;
    logic [63:0] addr;

    op_idx++;
    opc  = 8'(8'h3B ^ op_idx);
    addr = 64'h0123_4567_89AB_CDEF ^ 64'(op_idx * 3);
    {cap_rx_quad, cap_rx_dual, cap_tx_quad, cap_tx_dual} = caps;
    m_cw = cw; m_aw = aw; m_alen = alen; m_dw = dw; m_dlen = dlen;
    m_xw = xw; m_nd = nd; m_rd = rdf;
    op_opcode      = opc;
    op_cmd_lanes   = 3'(cw);
    op_addr_lanes  = 3'(aw);
    op_addr_len    = 4'(alen);
    op_addr        = addr;
    op_dummy_lanes = 3'(dw);
    op_dummy_len   = 4'(dlen);
    op_data_lanes  = 3'(xw);
    op_data_len    = 12'(nd);
    op_data_read   = (rdf != 0);

    exp_ok = lane_ok_b(cw, caps[0], caps[1])
          && (alen == 0 || lane_ok_b(aw, caps[0], caps[1]))
          && (dlen == 0 || lane_ok_b(dw, caps[0], caps[1]))
          && (nd == 0 || (rdf != 0 ? lane_ok_b(xw, caps[2], caps[3])
                                   : lane_ok_b(xw, caps[0], caps[1])));

    falls0 = cs_falls;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    cyc = 0; widx = 0; ridx = 0; hung = 0; saw_busy = 0;
    forever begin
      if (done) break;
      if (busy) saw_busy = 1;
      if (poke && cyc == 12) begin
        start = 1'b1;
        op_opcode = ~opc;
        op_cmd_lanes = 3'd3;
      end else begin
        start = 1'b0;
      end
      rd_ready = ((cyc + op_idx) % 4) != 1;
      if (rd_valid && rd_ready) begin
        if (ridx < 16) got[ridx] = int'(rd_data);
        ridx++;
      end
      wr_valid = (widx < nd) && (((cyc + op_idx) % 3) != 0);
      wr_data  = 8'(wr_pat(widx, op_idx));
      if (wr_valid && wr_ready) widx++;
      cyc++;
      if (cyc > 5000) begin hung = 1; break; end
      @(negedge clk);
    end
    start = 1'b0; wr_valid = 1'b0; rd_ready = 1'b0;

    check(!hung, "R12", "watchdog, done never seen", cyc, 0);
    if (hung) return;

    check(err_unsup == !exp_ok, "R2", "err_unsup vs capability rule",
          err_unsup, !exp_ok);
    check(cs_n == 1'b1 && sclk == 1'b0, "R8", "cs_n/sclk at done",
          {cs_n, sclk}, 2'b10);
    if (!exp_ok) begin
      check(cs_falls == falls0 && cyc == 0, "R3", "refused op: cs falls / done latency",
            (cs_falls - falls0) * 1000 + cyc, 0);
    end else begin
      check(err_io == 1'b0, "R11", "err_io on completed op", err_io, 0);
      check(saw_busy, "R12", "busy during op", saw_busy, 1);
      n_edges = 8 / cw + alen * (8 / aw) + dlen * (8 / dw) + nd * (8 / xw);
      check(k == n_edges, "R1", "sclk rising edge count", k, n_edges);
      // expected transmitted byte list with widths
      nb = 0;
      expb[nb] = int'(opc); wid[nb] = cw; nb++;
      for (int i = 0; i < alen; i++) begin
        expb[nb] = int'((addr >> (8 * (alen - 1 - i))) & 64'hFF); wid[nb] = aw; nb++;
      end
      for (int i = 0; i < dlen; i++) begin
        expb[nb] = 255; wid[nb] = dw; nb++;
      end
      if (rdf == 0) begin
        for (int i = 0; i < nd; i++) begin
          expb[nb] = wr_pat(i, op_idx); wid[nb] = xw; nb++;
        end
      end
      e = 0; bad_tx = 0; bad_oe = 0;
      if (k == n_edges) begin
        for (int i = 0; i < nb; i++) begin
          int b, msk;
          b = 0;
          msk = (1 << wid[i]) - 1;
          for (int g = 0; g < 8 / wid[i]; g++) begin
            b = (b << wid[i]) | (int'(cap_out[e]) & msk);
            if (int'(cap_oe[e]) != msk) bad_oe++;
            e++;
          end
          if (b != expb[i]) begin
            bad_tx++;
            $display("  byte %0d: saw %0h want %0h", i, b, expb[i]);
          end
        end
        for (int i = e; i < n_edges; i++)
          if (cap_oe[i] != 4'b0000) bad_oe++;
      end
      check(bad_tx == 0, "R4", "transmitted opcode/address/dummy/write bytes (R1 R5)",
            bad_tx, 0);
      check(bad_oe == 0, "R6", "lane enables per edge", bad_oe, 0);
      if (rdf != 0) begin
        bad_rd = 0;
        for (int i = 0; i < nd && i < 16; i++)
          if (got[i] != rd_pat(i, op_idx)) bad_rd++;
        check(ridx == nd && bad_rd == 0, "R10", "read stream count/data (R6 lane map)",
              ridx * 256 + bad_rd, nd * 256);
      end else begin
        check(widx == nd, "R9", "write stream bytes taken", widx, nd);
      end
      if (poke) begin
        repeat (4) begin
          @(negedge clk);
          check(!done && cs_n && !busy, "R12", "start while busy ignored",
                {done, cs_n, busy}, 3'b010);
        end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    check(0, "R12", "global watchdog expired", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int lanes [3] = '{1, 2, 4};
    rst_n = 1'b0; start = 1'b0;
    wr_valid = 1'b0; wr_data = '0; rd_ready = 1'b0;
    {cap_rx_quad, cap_rx_dual, cap_tx_quad, cap_tx_dual} = 4'hF;
    op_opcode = '0; op_cmd_lanes = 3'd1; op_addr_lanes = 3'd1; op_addr_len = '0;
    op_addr = '0; op_dummy_lanes = 3'd1; op_dummy_len = '0; op_data_lanes = 3'd1;
    op_data_len = '0; op_data_read = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    check(cs_n == 1'b1 && sclk == 1'b0 && io_oe == 4'b0, "R8", "reset: cs_n/sclk/oe",
          {cs_n, sclk, io_oe}, 6'b100000);
    check(!busy && !done && !rd_valid && !wr_ready, "R12", "reset: status idle",
          {busy, done, rd_valid, wr_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // capability sweep: opcode width, read width, write width over all capability sets
    for (int c = 0; c < 16; c++) begin
      for (int w = 0; w < 8; w++) begin
        run_op(w, 3, 0, 5, 0, 1, 0, 0, 4'(c), 0);   // R2: zero-length parts unjudged
        run_op(1, 1, 0, 1, 0, w, 1, 1, 4'(c), 0);   // R2: read judged on rx side
        run_op(1, 1, 0, 1, 0, w, 1, 0, 4'(c), 0);   // R2: write judged on tx side
      end
    end

    // width / length sweep over every combination of part widths
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int d = 0; d < 3; d++)
          for (int x = 0; x < 3; x++) begin
            int idx;
            idx = ((a * 3 + b) * 3 + d) * 3 + x;
            run_op(lanes[a], lanes[b], idx % 9, lanes[d], idx % 3, lanes[x],
                   idx % 4, (idx / 2) % 2, 4'hF, 0);
          end

    // start pulse and descriptor change during a long read and a long write
    run_op(1, 1, 8, 1, 2, 1, 3, 1, 4'hF, 1);
    run_op(2, 4, 8, 2, 2, 1, 3, 0, 4'hF, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule